// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-facing side of a block-transfer management mailbox. A host CPU sees three byte registers: control/status, a shared data port and an interrupt mask. Request bytes go into an inbound buffer through the data port. Response bytes come out of an outbound buffer through the same data port. Busy and attention flags in the control register carry the handshake. The host can be told of a response or an unsolicited message through a level interrupt.

On the other side sits a message processor. When the host marks a request ready, the processor gets a one-cycle event. It reads the request bytes by index and loads a response into the outbound buffer with a write port. A commit strobe then publishes the response. Two more strobes raise and drop the unsolicited-message attention flag. Both buffers hold `DEPTH` bytes each, 64 by default.

Top module: `bxfer_host_port`

## Requirements
- R1: `host_addr` 0 selects control/status, 1 the data port and 2 the mask register. A read at address 3 returns 0xFF. After reset, control and mask both read 0x00.
- R2: A control read returns device-busy in bit 7, host-busy in bit 6, message attention in bit 4 and response attention in bit 3. Bits 0, 1, 2 and 5 always read 0.
- R3: A control write with bit 0 set makes `in_count` zero on the next cycle. A control write with bit 1 set rewinds the outbound read position, so the next data read returns the first response byte again.
- R4: A control write with bit 3 set clears response attention. Bit 4 set clears message attention. Bit 6 set inverts host-busy.
- R5: A control write with bit 2 set sets device-busy and pulses `req_evt` high for exactly one cycle, starting the cycle after the write. If this write lands in the same cycle as a commit, device-busy ends up set.
- R6: A data-port write stores the byte at index `in_count` only while `in_count` < DEPTH. `in_count` increases on every data write, saturating at its all-ones value, so an overrun stays visible. Stored bytes read back on `in_rdata` at `in_raddr`.
- R7: While the outbound position is below the outbound length, a data read returns the byte at that position and advances the position. Reading the last byte sets both position and length to zero. With nothing pending, a data read returns 0xFF.
- R8: `rsp_commit` sets the outbound length to `rsp_len`, capped at DEPTH, and rewinds the position. It also clears device-busy, sets response attention, and sets interrupt-pending if the interrupt is enabled.
- R9: `sms_set` sets message attention. When that flag was clear and the interrupt is enabled, it also sets pending. `sms_clr` clears message attention. When that flag was set and response attention is clear, it also clears pending.
- R10: Mask bit 0 is enable and bit 1 is pending. Changing enable from 0 to 1 while either attention flag is set sets pending. Changing it from 1 to 0 clears pending. Writing 1 to bit 1 clears pending.
- R11: `host_irq` equals the pending bit. Reset clears both pending and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while `host_rd` is high |
| host_irq | output | 1 | Level interrupt to the host |
| req_evt | output | 1 | One-cycle request-ready event to the processor |
| in_raddr | input | AW | Processor index into the inbound buffer |
| in_rdata | output | 8 | Inbound byte at `in_raddr` |
| in_count | output | CNT_W | Inbound byte count, including overrun |
| rsp_we | input | 1 | Processor write to the outbound buffer |
| rsp_waddr | input | AW | Outbound buffer write index |
| rsp_wdata | input | 8 | Outbound buffer write data |
| rsp_commit | input | 1 | Publish the loaded response |
| rsp_len | input | LEN_W | Response length for the commit |
| sms_set | input | 1 | Raise message attention |
| sms_clr | input | 1 | Drop message attention |

## Verification
The bench builds the block with DEPTH = 4. A 4-byte inbound buffer makes the overrun path easy to reach: a six-byte request leaves the stored bytes unchanged while `in_count` keeps counting. The 3-bit response length can also exceed the buffer, so the commit cap is exercised. The interrupt sequences cover both attention sources combined with enabling, disabling and acknowledging.

// File: rtl/bxh_pkg.sv
package bxh_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int CB_CLR_IN    = 0;
  localparam int CB_CLR_OUT   = 1;
  localparam int CB_REQ       = 2;
  localparam int CB_ACK_RSP   = 3;
  localparam int CB_ACK_SMS   = 4;
  localparam int CB_HOST_BUSY = 6;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  typedef struct packed {
    logic dev_busy;
    logic host_busy;
    logic sms_attn;
    logic rsp_attn;
  } flags_t;

  function automatic logic [7:0] pack_ctrl(flags_t f);
    return {f.dev_busy, f.host_busy, 1'b0, f.sms_attn, f.rsp_attn, 3'b000};
  endfunction

  function automatic logic [7:0] pack_mask(logic en, logic pend);
    return {6'b0, pend, en};
  endfunction
endpackage

// File: rtl/bxh_inbuf.sv
module bxh_inbuf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             clr,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic       room;

  assign room    = count < CNT_W'(DEPTH);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr && room) mem[count[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (wr && count != '1)  count <= count + 1'b1;
  end

  p_count_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && count != '1) |=> count == $past(count) + 1'b1);
  p_count_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && count == '1) |=> count == '1);
endmodule

// File: rtl/bxh_outbuf.sv
module bxh_outbuf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [7:0]       ld_data,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             pop,
  input  logic             clr_pos,
  output logic [7:0]       rd_byte,
  output logic             avail,
  output logic [LEN_W-1:0] len
);
  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] pos;
  logic             last;

  function automatic logic [LEN_W-1:0] cap_len(logic [LEN_W-1:0] l);
    return (l > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : l;
  endfunction

  assign avail   = pos < len;
  assign last    = (pos + 1'b1) == len;
  assign rd_byte = avail ? mem[pos[AW-1:0]] : 8'hFF;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      len <= '0;
    end else if (commit) begin
      pos <= '0;
      len <= cap_len(commit_len);
    end else if (clr_pos) begin
      pos <= '0;
    end else if (pop && avail) begin
      if (last) begin
        pos <= '0;
        len <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && avail && last && !commit && !clr_pos) |=> (len == '0 && !avail));
  p_len_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> len <= LEN_W'(DEPTH));
endmodule

// File: rtl/bxh_ctrl.sv
module bxh_ctrl
  import bxh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   ack_rsp,
  input  logic   ack_sms,
  input  logic   tog_host,
  input  logic   mask_wr,
  input  logic   mask_en,
  input  logic   mask_ack,
  input  logic   commit,
  input  logic   sms_set,
  input  logic   sms_clr,
  output flags_t flags,
  output logic   irq_en,
  output logic   irq_pend,
  output logic   req_evt
);
  flags_t f_n;
  logic   en_n, pend_n;

  always_comb begin
    f_n    = flags;
    en_n   = irq_en;
    pend_n = irq_pend;
    if (ack_rsp)  f_n.rsp_attn  = 1'b0;
    if (ack_sms)  f_n.sms_attn  = 1'b0;
    if (tog_host) f_n.host_busy = ~flags.host_busy;
    if (commit) begin
      f_n.dev_busy = 1'b0;
      f_n.rsp_attn = 1'b1;
      if (irq_en) pend_n = 1'b1;
    end
    if (sms_set && !flags.sms_attn) begin
      f_n.sms_attn = 1'b1;
      if (irq_en) pend_n = 1'b1;
    end else if (sms_clr && flags.sms_attn) begin
      f_n.sms_attn = 1'b0;
      if (!flags.rsp_attn) pend_n = 1'b0;
    end
    if (req) f_n.dev_busy = 1'b1;
    if (mask_wr) begin
      if (mask_en && !irq_en) begin
        en_n = 1'b1;
        if (flags.rsp_attn || flags.sms_attn) pend_n = 1'b1;
      end else if (!mask_en && irq_en) begin
        en_n   = 1'b0;
        pend_n = 1'b0;
      end
      if (mask_ack) pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
      req_evt  <= 1'b0;
    end else begin
      flags    <= f_n;
      irq_en   <= en_n;
      irq_pend <= pend_n;
      req_evt  <= req;
    end
  end

  p_pend_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> irq_en);
  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_evt |-> flags.dev_busy);
  p_commit_attn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> flags.rsp_attn);
endmodule

// File: rtl/bxfer_host_port.sv
module bxfer_host_port
  import bxh_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 2,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             host_irq,
  output logic             req_evt,
  input  logic [AW-1:0]    in_raddr,
  output logic [7:0]       in_rdata,
  output logic [CNT_W-1:0] in_count,
  input  logic             rsp_we,
  input  logic [AW-1:0]    rsp_waddr,
  input  logic [7:0]       rsp_wdata,
  input  logic             rsp_commit,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic             sms_set,
  input  logic             sms_clr
);
  logic       ctrl_wr, data_wr, mask_wr, data_rd;
  flags_t     flags;
  logic       irq_en, irq_pend, out_avail;
  logic [7:0] out_byte;
  logic [LEN_W-1:0] out_len;

  assign ctrl_wr = host_wr && host_addr == OFS_CTRL;
  assign data_wr = host_wr && host_addr == OFS_DATA;
  assign mask_wr = host_wr && host_addr == OFS_MASK;
  assign data_rd = host_rd && host_addr == OFS_DATA;

  bxh_inbuf #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_in (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(host_wdata),
    .clr(ctrl_wr && host_wdata[CB_CLR_IN]),
    .rd_addr(in_raddr), .rd_data(in_rdata), .count(in_count)
  );

  bxh_outbuf #(.DEPTH(DEPTH), .AW(AW), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ld_we(rsp_we), .ld_addr(rsp_waddr),
    .ld_data(rsp_wdata), .commit(rsp_commit), .commit_len(rsp_len),
    .pop(data_rd), .clr_pos(ctrl_wr && host_wdata[CB_CLR_OUT]),
    .rd_byte(out_byte), .avail(out_avail), .len(out_len)
  );

  bxh_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req(ctrl_wr && host_wdata[CB_REQ]),
    .ack_rsp(ctrl_wr && host_wdata[CB_ACK_RSP]),
    .ack_sms(ctrl_wr && host_wdata[CB_ACK_SMS]),
    .tog_host(ctrl_wr && host_wdata[CB_HOST_BUSY]),
    .mask_wr(mask_wr), .mask_en(host_wdata[MB_EN]), .mask_ack(host_wdata[MB_PEND]),
    .commit(rsp_commit), .sms_set(sms_set), .sms_clr(sms_clr),
    .flags(flags), .irq_en(irq_en), .irq_pend(irq_pend), .req_evt(req_evt)
  );

  always_comb begin
    unique case (host_addr)
      OFS_CTRL: host_rdata = pack_ctrl(flags);
      OFS_DATA: host_rdata = out_byte;
      OFS_MASK: host_rdata = pack_mask(irq_en, irq_pend);
      default:  host_rdata = 8'hFF;
    endcase
  end

  assign host_irq = irq_pend;

  p_clr_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && host_wdata[CB_CLR_IN]) |=> in_count == '0);
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && out_len == '0) |-> host_rdata == 8'hFF);
  p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> irq_en);
endmodule

// File: tb/test_bxfer_host_port.sv
module test_bxfer_host_port;
  localparam int DEPTH = 4;
  localparam int AW    = 2;
  localparam int CNT_W = 4;
  localparam int LEN_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_irq, req_evt;
  logic [AW-1:0] in_raddr = '0;
  logic [7:0] in_rdata;
  logic [CNT_W-1:0] in_count;
  logic rsp_we = 1'b0, rsp_commit = 1'b0, sms_set = 1'b0, sms_clr = 1'b0;
  logic [AW-1:0] rsp_waddr = '0;
  logic [7:0] rsp_wdata = '0;
  logic [LEN_W-1:0] rsp_len = '0;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bxfer_host_port #(.DEPTH(DEPTH)) i_bxfer_host_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .req_evt(req_evt), .in_raddr(in_raddr),
    .in_rdata(in_rdata), .in_count(in_count), .rsp_we(rsp_we),
    .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata), .rsp_commit(rsp_commit),
    .rsp_len(rsp_len), .sms_set(sms_set), .sms_clr(sms_clr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (host_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic pulse_sms(bit set);
    @(posedge clk); #1;
    if (set) sms_set = 1'b1; else sms_clr = 1'b1;
    @(posedge clk); #1;
    sms_set = 1'b0; sms_clr = 1'b0;
  endtask

  task automatic load_rsp(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                          logic [7:0] b3, logic [LEN_W-1:0] n);
    logic [7:0] bytes [4];
    bytes = '{b0, b1, b2, b3};
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      rsp_we = 1'b1; rsp_waddr = AW'(i); rsp_wdata = bytes[i];
    end
    @(posedge clk); #1;
    rsp_we = 1'b0; rsp_commit = 1'b1; rsp_len = n;
    @(posedge clk); #1;
    rsp_commit = 1'b0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 R2 R11 reset state
    rd(2'd0, 8'h00, "R1 ctrl after reset");
    rd(2'd2, 8'h00, "R11 mask after reset");
    rd(2'd3, 8'hFF, "R1 offset 3");
    check("R11 irq after reset", host_irq, 0);
    check("R6 count after reset", in_count, 0);
    // R6 inbound with overrun
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    wr(2'd1, 8'h44); wr(2'd1, 8'h55); wr(2'd1, 8'h66);
    check("R6 overrun count", in_count, 6);
    for (int i = 0; i < 4; i++) begin
      in_raddr = AW'(i); #1;
      check("R6 stored byte", in_rdata, 8'h11 * (i + 1));
    end
    // R3 clear write pointer
    wr(2'd0, 8'h01);
    check("R3 inbound cleared", in_count, 0);
    wr(2'd1, 8'h77);
    in_raddr = '0; #1;
    check("R3 restart at index 0", in_rdata, 8'h77);
    check("R6 count after restart", in_count, 1);
    // R5 request event
    wr(2'd0, 8'h04);
    check("R5 req_evt pulse", req_evt, 1);
    @(posedge clk); #1;
    check("R5 req_evt one cycle", req_evt, 0);
    rd(2'd0, 8'h80, "R5 R2 device busy");
    // R4 host busy toggle
    wr(2'd0, 8'h40);
    rd(2'd0, 8'hC0, "R4 host busy set");
    wr(2'd0, 8'h40);
    rd(2'd0, 8'h80, "R4 host busy cleared");
    // R10 enable with no attention
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h01, "R10 enable quiet");
    check("R11 irq quiet", host_irq, 0);
    // R8 commit response
    load_rsp(8'hA1, 8'hB2, 8'hC3, 8'hD4, 3'd3);
    rd(2'd0, 8'h08, "R8 busy off attn on");
    rd(2'd2, 8'h03, "R8 pending set");
    check("R11 irq follows pending", host_irq, 1);
    // R7 R3 reading and rewind
    rd(2'd1, 8'hA1, "R7 byte 0");
    rd(2'd1, 8'hB2, "R7 byte 1");
    wr(2'd0, 8'h02);
    rd(2'd1, 8'hA1, "R3 rewind");
    rd(2'd1, 8'hB2, "R7 byte 1 again");
    rd(2'd1, 8'hC3, "R7 last byte");
    rd(2'd1, 8'hFF, "R7 drained");
    wr(2'd0, 8'h02);
    rd(2'd1, 8'hFF, "R7 rewind after drain stays empty");
    // R10 acknowledge, R4 clear response attention
    wr(2'd2, 8'h03);
    rd(2'd2, 8'h01, "R10 ack clears pending");
    check("R11 irq after ack", host_irq, 0);
    wr(2'd0, 8'h08);
    rd(2'd0, 8'h00, "R4 response attn cleared");
    // R9 message attention
    pulse_sms(1'b1);
    check("R9 sms raises irq", host_irq, 1);
    rd(2'd0, 8'h10, "R9 R2 sms flag");
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h00, "R4 sms attn cleared");
    rd(2'd2, 8'h03, "R4 ack keeps pending");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R10 disable clears pending");
    check("R11 irq off", host_irq, 0);
    pulse_sms(1'b1);
    check("R9 disabled no irq", host_irq, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h03, "R10 enable with attn");
    pulse_sms(1'b0);
    rd(2'd2, 8'h01, "R9 sms_clr drops pending");
    rd(2'd0, 8'h00, "R9 sms flag dropped");
    // R8 length cap
    load_rsp(8'h01, 8'h02, 8'h03, 8'h04, 3'd7);
    rd(2'd1, 8'h01, "R8 capped 0");
    rd(2'd1, 8'h02, "R8 capped 1");
    rd(2'd1, 8'h03, "R8 capped 2");
    rd(2'd1, 8'h04, "R8 capped 3");
    rd(2'd1, 8'hFF, "R8 capped end");
    // R11 reset clears enable and pending
    check("R11 irq before reset", host_irq, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(2'd2, 8'h00, "R11 mask after reset");
    check("R11 irq after reset", host_irq, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule